// File: doc/BRIEF.md
# Switch Overcurrent Blanking and Deglitch Monitor

This block watches the six power switches of a three-phase bridge (one upper and one lower switch per phase) for overcurrent. Each switch has a digital trip input from an external voltage comparator across the switch: drain to phase node for an upper switch, phase node to low source for a lower switch. Each switch also has its gate-on command. After every commanded turn-on, a channel ignores its trip input for a programmable blanking window. After that, a trip counts only if the comparator stays high for a programmable deglitch time.

A recognised trip is handled according to a three-bit response code. In latched shutdown, a kill output forces all six gate drives low. In report-only, the gates are left alone and only the event is flagged. In the ignore setting, nothing happens. The fault pin and one sticky flag per switch tell the controller which switch tripped. A one-cycle clear pulse releases the flags and the kill. The five-bit comparator threshold setting is only passed through to the analog side. All configuration arrives as plain input fields.

Top module: `ocp_monitor`

## Requirements
- R1: After synchronous reset, `sw_flag` is all zero, `gate_kill` is 0 and `fault_n` is 1.
- R2: The blanking length comes from `timing_cfg[3:2]`: code 0 gives 0 cycles, 1 gives 16, 2 gives 32 and 3 gives 64. A channel starts blanking at the clock edge where its gate command is first seen high. Its trip input is ignored at that edge and at the next L edges, where L is the blanking length.
- R3: The deglitch length comes from `timing_cfg[1:0]`: code 0 gives 0 cycles, 1 gives 8, 2 gives 16 and 3 gives 32. Once blanking is over, a trip is recognised when the trip input is sampled high on D+1 consecutive edges, where D is the deglitch length. The flag shows after the edge that takes the last of those samples. Counting then starts afresh.
- R4: A trip pulse that drops before D+1 consecutive high samples is discarded and sets nothing.
- R5: The blanking code is captured at the edge that starts blanking. The deglitch code is captured at the first high sample. Changing either code while its timer runs does not alter that timer.
- R6: While a channel's gate command is low, its trip input is never recognised. Dropping the gate command cancels any blanking or deglitch in progress.
- R7: With `sense_cfg[2:0]` = 3'b000 (latched shutdown), a recognised trip sets that switch's flag and sets `gate_kill` at the same edge. `gate_kill` then stays high.
- R8: With `sense_cfg[2:0]` = 3'b001 (report only), a recognised trip sets that switch's flag and leaves `gate_kill` unchanged.
- R9: With `sense_cfg[2:0]` = 3'b010 (ignore), a recognised trip changes neither the flags nor `gate_kill`.
- R10: The codes 3'b011 to 3'b111 in `sense_cfg[2:0]` behave as latched shutdown.
- R11: Flags and `gate_kill` hold until an edge that samples `clear_flags` high, which zeroes them. A trip recognised at that same edge still sets its flag, and also sets the kill in a shutdown mode.
- R12: `fault_n` is low exactly when at least one flag is set.
- R13: `thresh_out` always equals `sense_cfg[7:3]`, without delay.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| gate_cmd | input | 6 | Gate-on command per switch: bits 0-2 are the upper switches of phases A-C, bits 3-5 the lower switches |
| trip_in | input | 6 | Comparator trip per switch, same bit order |
| timing_cfg | input | 4 | [3:2] blanking code, [1:0] deglitch code |
| sense_cfg | input | 8 | [7:3] comparator threshold, [2:0] response code |
| clear_flags | input | 1 | One-cycle clear of the flags and the kill |
| thresh_out | output | 5 | Threshold passed through to the comparators |
| gate_kill | output | 1 | Forces all six gate drives low |
| fault_n | output | 1 | Active-low fault indication |
| sw_flag | output | 6 | Sticky per-switch overcurrent flags |

## Verification
Suppose a channel's gate rise is sampled at edge k and its deglitch run begins with a high sample at edge j, which is no earlier than k+L+1. Then the flag, the fault pin and, in a shutdown mode, the kill all change at edge j+D. A clear takes effect at the edge that samples it. The threshold passes through in the same cycle. The bench drives inputs on the falling edge and advances a cycle-counting reference model on the rising edge. It compares every output at the following falling edge, so each result is checked in exactly the cycle it is due. Directed cases count the cycles explicitly across the blanking and deglitch boundaries.

// File: rtl/ocp_pkg.sv
package ocp_pkg;

    typedef enum logic [1:0] {
        CH_IDLE,
        CH_BLANK,
        CH_WATCH,
        CH_DEGL
    } ch_state_e;

    typedef enum logic [1:0] {
        RSP_SHUTDOWN,
        RSP_REPORT,
        RSP_IGNORE
    } rsp_e;

    localparam logic [2:0] MODE_REPORT = 3'b001;
    localparam logic [2:0] MODE_IGNORE = 3'b010;

    typedef struct packed {
        logic [1:0] blank_code;
        logic [1:0] degl_code;
    } timing_t;

    function automatic rsp_e decode_mode(input logic [2:0] code);
        if (code == MODE_REPORT) return RSP_REPORT;
        if (code == MODE_IGNORE) return RSP_IGNORE;
        return RSP_SHUTDOWN;
    endfunction

    function automatic int unsigned code_to_cycles(input logic [1:0] code,
                                                   input int unsigned unit);
        if (code == 2'd0) return 0;
        return unit << (code - 2'd1);
    endfunction

endpackage

// File: rtl/ocp_channel.sv
module ocp_channel
    import ocp_pkg::*;
#(
    parameter int unsigned BLANK_UNIT = 16,
    parameter int unsigned DEGL_UNIT  = 8,
    parameter int unsigned CNT_W      = 7
) (
    input  logic    clk,
    input  logic    rst,
    input  logic    gate,
    input  logic    trip,
    input  timing_t tcfg,
    output logic    confirm
);

    ch_state_e        st;
    logic [CNT_W-1:0] cnt;
    logic [CNT_W-1:0] blank_len;
    logic [CNT_W-1:0] degl_len;

    always_comb begin
        blank_len = CNT_W'(code_to_cycles(tcfg.blank_code, BLANK_UNIT));
        degl_len  = CNT_W'(code_to_cycles(tcfg.degl_code, DEGL_UNIT));
    end

    always_comb begin
        confirm = 1'b0;
        if (gate && trip) begin
            if (st == CH_WATCH && degl_len == '0) confirm = 1'b1;
            if (st == CH_DEGL && cnt == '0)       confirm = 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            st  <= CH_IDLE;
            cnt <= '0;
        end else if (!gate) begin
            st  <= CH_IDLE;
            cnt <= '0;
        end else begin
            unique case (st)
                CH_IDLE: begin
                    if (blank_len == '0) begin
                        st <= CH_WATCH;
                    end else begin
                        st  <= CH_BLANK;
                        cnt <= blank_len - 1'b1;
                    end
                end
                CH_BLANK: begin
                    if (cnt == '0) st <= CH_WATCH;
                    else           cnt <= cnt - 1'b1;
                end
                CH_WATCH: begin
                    if (trip && degl_len != '0) begin
                        st  <= CH_DEGL;
                        cnt <= degl_len - 1'b1;
                    end
                end
                CH_DEGL: begin
                    if (!trip || cnt == '0) st <= CH_WATCH;
                    else                    cnt <= cnt - 1'b1;
                end
                default: st <= CH_IDLE;
            endcase
        end
    end

endmodule

// File: rtl/ocp_response.sv
module ocp_response
    import ocp_pkg::*;
#(
    parameter int unsigned N_SW = 6
) (
    input  logic            clk,
    input  logic            rst,
    input  logic [N_SW-1:0] confirm,
    input  logic [2:0]      mode,
    input  logic            clear,
    output logic [N_SW-1:0] flags,
    output logic            kill
);

    rsp_e            rsp;
    logic [N_SW-1:0] new_flags;
    logic            new_kill;

    always_comb begin
        rsp       = decode_mode(mode);
        new_flags = (rsp == RSP_IGNORE) ? '0 : confirm;
        new_kill  = (rsp == RSP_SHUTDOWN) && (|confirm);
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            flags <= '0;
            kill  <= 1'b0;
        end else begin
            flags <= (clear ? '0 : flags) | new_flags;
            kill  <= (clear ? 1'b0 : kill) | new_kill;
        end
    end

endmodule

// File: rtl/ocp_monitor.sv
module ocp_monitor
    import ocp_pkg::*;
#(
    parameter int unsigned N_SW       = 6,
    parameter int unsigned THR_W      = 5,
    parameter int unsigned BLANK_UNIT = 16,
    parameter int unsigned DEGL_UNIT  = 8
) (
    input  logic               clk,
    input  logic               rst,
    input  logic [N_SW-1:0]    gate_cmd,
    input  logic [N_SW-1:0]    trip_in,
    input  logic [3:0]         timing_cfg,
    input  logic [THR_W+2:0]   sense_cfg,
    input  logic               clear_flags,
    output logic [THR_W-1:0]   thresh_out,
    output logic               gate_kill,
    output logic               fault_n,
    output logic [N_SW-1:0]    sw_flag
);

    localparam int unsigned MAX_LEN = (BLANK_UNIT > DEGL_UNIT) ? BLANK_UNIT * 4 : DEGL_UNIT * 4;
    localparam int unsigned CNT_W   = $clog2(MAX_LEN + 1);

    timing_t         tcfg;
    logic [N_SW-1:0] confirm;

    assign tcfg       = timing_t'(timing_cfg);
    assign thresh_out = sense_cfg[THR_W+2:3];

    for (genvar i = 0; i < N_SW; i++) begin : g_ch
        ocp_channel #(
            .BLANK_UNIT(BLANK_UNIT),
            .DEGL_UNIT (DEGL_UNIT),
            .CNT_W     (CNT_W)
        ) u_ch (
            .clk    (clk),
            .rst    (rst),
            .gate   (gate_cmd[i]),
            .trip   (trip_in[i]),
            .tcfg   (tcfg),
            .confirm(confirm[i])
        );
    end

    ocp_response #(.N_SW(N_SW)) u_rsp (
        .clk    (clk),
        .rst    (rst),
        .confirm(confirm),
        .mode   (sense_cfg[2:0]),
        .clear  (clear_flags),
        .flags  (sw_flag),
        .kill   (gate_kill)
    );

    assign fault_n = ~(|sw_flag);

endmodule

// File: rtl/ocp_checker.sv
module ocp_checker #(
    parameter int unsigned N_SW  = 6,
    parameter int unsigned THR_W = 5
) (
    input logic             clk,
    input logic             rst,
    input logic [N_SW-1:0]  gate_cmd,
    input logic [N_SW-1:0]  trip_in,
    input logic [THR_W+2:0] sense_cfg,
    input logic             clear_flags,
    input logic             gate_kill,
    input logic             fault_n,
    input logic [N_SW-1:0]  sw_flag
);

    a_r6_gate_low_no_new_flag: assert property (@(posedge clk) disable iff (rst)
        (gate_cmd == '0) |=> ((sw_flag & ~$past(sw_flag)) == '0));

    a_r3_no_trip_no_new_flag: assert property (@(posedge clk) disable iff (rst)
        (trip_in == '0) |=> ((sw_flag & ~$past(sw_flag)) == '0));

    a_r7_kill_has_flag: assert property (@(posedge clk) disable iff (rst)
        gate_kill |-> (sw_flag != '0));

    a_r8_report_keeps_kill_low: assert property (@(posedge clk) disable iff (rst)
        (sense_cfg[2:0] == 3'b001 && !gate_kill) |=> !gate_kill);

    a_r9_ignore_no_change: assert property (@(posedge clk) disable iff (rst)
        (sense_cfg[2:0] == 3'b010 && !clear_flags) |=> (sw_flag == $past(sw_flag) && gate_kill == $past(gate_kill)));

    a_r11_flags_sticky: assert property (@(posedge clk) disable iff (rst)
        !clear_flags |=> ((sw_flag & $past(sw_flag)) == $past(sw_flag)));

    a_r11_clear_releases: assert property (@(posedge clk) disable iff (rst)
        (clear_flags && trip_in == '0) |=> (sw_flag == '0 && !gate_kill));

    a_r12_fault_pin: assert property (@(posedge clk) disable iff (rst)
        (fault_n == (sw_flag == '0)));

endmodule

bind ocp_monitor ocp_checker #(.N_SW(N_SW), .THR_W(THR_W)) u_chk (
    .clk        (clk),
    .rst        (rst),
    .gate_cmd   (gate_cmd),
    .trip_in    (trip_in),
    .sense_cfg  (sense_cfg),
    .clear_flags(clear_flags),
    .gate_kill  (gate_kill),
    .fault_n    (fault_n),
    .sw_flag    (sw_flag)
);

// File: tb/sim_ocp_monitor.sv
module sim_ocp_monitor;

    logic       clk = 1'b0;
    logic       rst;
    logic [5:0] gate_cmd;
    logic [5:0] trip_in;
    logic [3:0] timing_cfg;
    logic [7:0] sense_cfg;
    logic       clear_flags;
    logic [4:0] thresh_out;
    logic       gate_kill;
    logic       fault_n;
    logic [5:0] sw_flag;

    always #5 clk = ~clk;

    ocp_monitor u0 (
        .clk(clk), .rst(rst), .gate_cmd(gate_cmd), .trip_in(trip_in),
        .timing_cfg(timing_cfg), .sense_cfg(sense_cfg), .clear_flags(clear_flags),
        .thresh_out(thresh_out), .gate_kill(gate_kill), .fault_n(fault_n), .sw_flag(sw_flag)
    );

    int n_cmp = 0;
    int n_bad = 0;
    string req = "R1";

    int   since [6];
    int   lc    [6];
    int   run   [6];
    int   dc    [6];
    logic [5:0] e_flags;
    logic       e_kill;

    function automatic int blank_cyc(input logic [1:0] c);
        case (c)
            2'd0: return 0;
            2'd1: return 16;
            2'd2: return 32;
            default: return 64;
        endcase
    endfunction

    function automatic int degl_cyc(input logic [1:0] c);
        case (c)
            2'd0: return 0;
            2'd1: return 8;
            2'd2: return 16;
            default: return 32;
        endcase
    endfunction

    task automatic model_reset();
        for (int i = 0; i < 6; i++) begin
            since[i] = -1; lc[i] = 0; run[i] = 0; dc[i] = 0;
        end
        e_flags = '0;
        e_kill  = 1'b0;
    endtask

    task automatic model_step();
        logic [5:0] conf;
        logic [2:0] m;
        conf = '0;
        for (int i = 0; i < 6; i++) begin
            if (!gate_cmd[i]) begin
                since[i] = -1; run[i] = 0;
            end else if (since[i] < 0) begin
                since[i] = 0; lc[i] = blank_cyc(timing_cfg[3:2]); run[i] = 0;
            end else begin
                if (since[i] < 100000) since[i] = since[i] + 1;
                if (since[i] > lc[i]) begin
                    if (trip_in[i]) begin
                        if (run[i] == 0) dc[i] = degl_cyc(timing_cfg[1:0]);
                        run[i] = run[i] + 1;
                        if (run[i] == dc[i] + 1) begin
                            conf[i] = 1'b1; run[i] = 0;
                        end
                    end else begin
                        run[i] = 0;
                    end
                end
            end
        end
        m = sense_cfg[2:0];
        if (clear_flags) begin
            e_flags = '0; e_kill = 1'b0;
        end
        if (m != 3'b010) e_flags = e_flags | conf;
        if (m != 3'b001 && m != 3'b010 && conf != '0) e_kill = 1'b1;
    endtask

    task automatic check_vec(input string r, input string what, input logic [7:0] act, input logic [7:0] exp);
        n_cmp++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s %s actual=%0h expected=%0h t=%0t", r, what, act, exp, $time);
        end
    endtask

    task automatic check_all();
        check_vec(req, "sw_flag", {2'b0, sw_flag}, {2'b0, e_flags});
        check_vec(req, "gate_kill", {7'b0, gate_kill}, {7'b0, e_kill});
        check_vec("R12", "fault_n", {7'b0, fault_n}, {7'b0, ~(|e_flags)});
        check_vec("R13", "thresh_out", {3'b0, thresh_out}, {3'b0, sense_cfg[7:3]});
    endtask

    task automatic tick();
        @(posedge clk);
        if (rst) model_reset(); else model_step();
        @(negedge clk);
        check_all();
    endtask

    task automatic ticks(input int n);
        for (int k = 0; k < n; k++) tick();
    endtask

    task automatic quiet();
        gate_cmd = '0; trip_in = '0; clear_flags = 1'b1;
        tick();
        clear_flags = 1'b0;
        tick();
    endtask

    task automatic summary();
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        n_bad++;
        $display("FAIL watchdog expired");
        summary();
        $finish;
    end

    initial begin
        void'($urandom(32'd4242));
        rst = 1'b1; gate_cmd = '0; trip_in = '0; timing_cfg = '0;
        sense_cfg = 8'b1010_1000; clear_flags = 1'b0;
        model_reset();
        ticks(3);
        rst = 1'b0;
        req = "R1";
        tick();
        check_vec("R1", "reset flags", {2'b0, sw_flag}, 8'h00);
        check_vec("R1", "reset kill/fault_n", {6'b0, gate_kill, fault_n}, 8'h01);

        // R2: blanking of 16 cycles, no deglitch, report only
        req = "R2";
        timing_cfg = 4'b01_00; sense_cfg = 8'b0001_0001;
        gate_cmd = 6'b000001; trip_in = 6'b000001;
        ticks(17);
        check_vec("R2", "flag inside blank", {7'b0, sw_flag[0]}, 8'h00);
        tick();
        check_vec("R2", "flag after blank", {7'b0, sw_flag[0]}, 8'h01);
        check_vec("R8", "report keeps kill low", {7'b0, gate_kill}, 8'h00);
        quiet();

        // R3: deglitch of 8 cycles, no blank
        req = "R3";
        timing_cfg = 4'b00_01;
        gate_cmd = 6'b001000; tick();
        trip_in = 6'b001000;
        ticks(8);
        check_vec("R3", "flag before D+1 samples", {7'b0, sw_flag[3]}, 8'h00);
        tick();
        check_vec("R3", "flag after D+1 samples", {7'b0, sw_flag[3]}, 8'h01);
        quiet();

        // R4: pulse one sample short of recognition
        req = "R4";
        timing_cfg = 4'b00_10;
        gate_cmd = 6'b000010; tick();
        trip_in = 6'b000010; ticks(16);
        trip_in = '0; ticks(3);
        check_vec("R4", "short pulse discarded", {2'b0, sw_flag}, 8'h00);
        quiet();

        // R5: codes captured when timers start
        req = "R5";
        timing_cfg = 4'b11_00;
        gate_cmd = 6'b000100; trip_in = 6'b000100; tick();
        timing_cfg = 4'b00_00;
        ticks(40);
        check_vec("R5", "blank keeps captured length", {7'b0, sw_flag[2]}, 8'h00);
        ticks(25);
        check_vec("R5", "flag after 64-cycle blank", {7'b0, sw_flag[2]}, 8'h01);
        quiet();
        timing_cfg = 4'b00_01;
        gate_cmd = 6'b010000; tick();
        trip_in = 6'b010000; tick();
        timing_cfg = 4'b00_11; ticks(8);
        check_vec("R5", "deglitch keeps captured length", {7'b0, sw_flag[4]}, 8'h01);
        quiet();

        // R6: gate low never trips; gate drop cancels deglitch
        req = "R6";
        timing_cfg = 4'b00_00; gate_cmd = '0; trip_in = 6'b111111; ticks(5);
        check_vec("R6", "gate low ignores trip", {2'b0, sw_flag}, 8'h00);
        timing_cfg = 4'b00_01; gate_cmd = 6'b100000; trip_in = '0; tick();
        trip_in = 6'b100000; ticks(5);
        gate_cmd = '0; tick();
        gate_cmd = 6'b100000; trip_in = '0; tick();
        trip_in = 6'b100000; ticks(5);
        check_vec("R6", "cancelled deglitch restarts", {7'b0, sw_flag[5]}, 8'h00);
        quiet();

        // R7 / R10: latched shutdown
        req = "R7";
        timing_cfg = 4'b00_00; sense_cfg = 8'b0110_0000;
        gate_cmd = 6'b000001; tick(); trip_in = 6'b000001; tick();
        trip_in = '0; ticks(4);
        check_vec("R7", "kill latched", {6'b0, gate_kill, sw_flag[0]}, 8'h03);
        quiet();
        req = "R10";
        sense_cfg = 8'b0110_0101;
        gate_cmd = 6'b000010; tick(); trip_in = 6'b000010; tick(); trip_in = '0; tick();
        check_vec("R10", "undefined code shuts down", {6'b0, gate_kill, sw_flag[1]}, 8'h03);
        quiet();

        // R9: ignore mode
        req = "R9";
        sense_cfg = 8'b0110_0010;
        gate_cmd = 6'b111111; tick(); trip_in = 6'b111111; ticks(4);
        check_vec("R9", "ignore sets nothing", {1'b0, gate_kill, sw_flag}, 8'h00);
        quiet();

        // R11: clear and recognition at the same edge
        req = "R11";
        sense_cfg = 8'b0110_0000;
        gate_cmd = 6'b000011; tick(); trip_in = 6'b000001; tick();
        trip_in = 6'b000010; clear_flags = 1'b1; tick();
        clear_flags = 1'b0; trip_in = '0;
        check_vec("R11", "clear then set same edge", {1'b0, gate_kill, sw_flag}, 8'h42);
        ticks(3);
        check_vec("R11", "sticky after clear", {1'b0, gate_kill, sw_flag}, 8'h42);
        quiet();

        // Random phase: all requirements against the reference model
        req = "R2/R3 random";
        for (int blk = 0; blk < 16; blk++) begin
            timing_cfg = 4'($urandom);
            sense_cfg  = {5'($urandom), 3'($urandom % 8)};
            for (int c = 0; c < 250; c++) begin
                for (int i = 0; i < 6; i++) begin
                    if ($urandom % 40 == 0) gate_cmd[i] = ~gate_cmd[i];
                    if ($urandom % 5 == 0)  trip_in[i]  = ~trip_in[i];
                end
                clear_flags = ($urandom % 300 == 0);
                if ($urandom % 500 == 0) timing_cfg = 4'($urandom);
                tick();
            end
        end
        clear_flags = 1'b0;

        summary();
        $finish;
    end

endmodule